// File: doc/BRIEF.md
# Capture and Auto-Reload Timer, 16-bit

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register. All of its timing is taken from a machine-cycle strobe. The strobe is made by dividing the clock by `PRESCALE`, which defaults to 12.

- **Timer function:** the count advances once per machine cycle.
- **Counter function:** the count advances once for each falling edge seen on the count pin. The pin is sampled once per machine cycle, and an edge is a high sample followed by a low sample.
- **Direction pin:** a second external pin is sampled in the same way. Its falling edges trigger a capture or a reload. When down-counting is enabled, its level sets the count direction instead.

Software controls the block through plain register-style inputs: run, counter select, capture select, external enable, down-count enable and an idle select. The idle select stands for a mode this block does not implement, and it freezes the timer. Software writes the count and the capture/reload register through write strobes. It clears the two sticky flags, overflow and event, with clear pulses. An interrupt request is derived from the two flags.

All inputs are synchronous to `clk`. The block has no streaming data path, so every pin is a plain level or a one-cycle strobe with no handshake.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the count, the capture/reload register, both flags and the interrupt request are all 0.
- R2: In timer function (counter select 0), with run at 1 and idle select at 0, the count changes exactly once every `PRESCALE` clocks. The first change comes `PRESCALE` clocks after run rises.
- R3: In counter function (counter select 1), the count pin is sampled at each machine-cycle strobe. A sample of 1 followed by a sample of 0 advances the count by one at the next strobe after the strobe that saw the 0. A pin held low advances it only once.
- R4: With run at 0, or with idle select at 1, the count and both flags hold their values. Machine-cycle timing restarts from zero when run rises.
- R5: In capture mode (capture select 1), the count wraps from 0xFFFF to 0x0000 and sets the overflow flag.
- R6: In capture mode with external enable at 1, a sampled falling edge on the direction pin copies the count into the capture/reload register and sets the event flag. With external enable at 0, such an edge changes neither of them.
- R7: In reload mode (capture select 0) with down-count enable at 0, a step from 0xFFFF loads the reload value and sets the overflow flag. With external enable at 1, a sampled falling edge on the direction pin forces the reload and sets the event flag.
- R8: With down-count enable at 1 and the direction pin at 1, the count goes up. A step from 0xFFFF loads the reload value and sets the overflow flag.
- R9: With down-count enable at 1 and the direction pin at 0, the count goes down by one per step. A step taken while the count equals the reload value loads 0xFFFF and sets the overflow flag.
- R10: With down-count enable at 1, the event flag toggles on every overflow and every underflow.
- R11: The interrupt request is high when the overflow flag is set, or when the event flag is set and down-count enable is 0. Each flag stays set until its clear pulse.
- R12: A count write strobe loads the count from its data input, and a reload write strobe loads the capture/reload register. Either new value is visible on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run control; 0 stops the timer |
| cnt_sel_i | input | 1 | 1 = count pin edges, 0 = machine cycles |
| cap_sel_i | input | 1 | 1 = capture mode, 0 = reload mode |
| ext_en_i | input | 1 | Enables capture/reload on direction-pin falling edges |
| dn_en_i | input | 1 | Enables up/down counting in reload mode |
| idle_sel_i | input | 1 | Selects the unimplemented mode; freezes the timer |
| cnt_pin_i | input | 1 | External count pin |
| dir_pin_i | input | 1 | External trigger / direction pin |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| rld_we_i | input | 1 | Capture/reload register write strobe |
| rld_wdata_i | input | 16 | Capture/reload register write data |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| evt_clr_i | input | 1 | Clears the event flag |
| count_o | output | 16 | Current count |
| rld_o | output | 16 | Capture/reload register |
| ovf_o | output | 1 | Overflow flag |
| evt_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the wrap points in each direction and the register-match underflow. A design that compared the count against zero rather than the reload value would underflow at the wrong count. A design that loaded 0x0000 after an underflow would break the expected sequence from 0xFFFF downward.

A back-to-back overflow with the reload value at 0xFFFF must toggle the event flag twice and leave it clear. A design that sets the flag instead of toggling it would leave it high.

The count-pin test checks the one-machine-cycle lag after edge detection and that a pin held low counts only once. A counter that is edge-blind or has no lag shows up there. The interrupt masking of the event flag in up/down mode is also exercised, along with the ignored capture edge when external enable is 0.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_CAPTURE  = 2'd1,
    MODE_RELOAD   = 2'd2,
    MODE_UPDOWN   = 2'd3
  } crt_mode_e;

  function automatic crt_mode_e decode_mode(input logic active, input logic cap_sel,
                                            input logic dn_en);
    if (!active)      return MODE_OFF;
    else if (cap_sel) return MODE_CAPTURE;
    else if (dn_en)   return MODE_UPDOWN;
    else              return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/crt_prescale.sv
module crt_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] div_q;

  assign tick = en && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) div_q <= '0;
    else if (tick)     div_q <= '0;
    else               div_q <= div_q + ONE;
  end
endmodule

// File: rtl/crt_edge_sampler.sv
module crt_edge_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  // One sample per machine cycle; a detected edge is held for the following cycle.
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic smp_q;
    logic fall_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        smp_q  <= 1'b0;
        fall_q <= 1'b0;
      end else if (!en) begin
        fall_q <= 1'b0;
      end else if (tick) begin
        smp_q  <= pin[g];
        fall_q <= smp_q & ~pin[g];
      end
    end
    assign fall[g] = fall_q;
  end
endmodule

// File: rtl/crt_core.sv
module crt_core
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  crt_mode_e    mode,
  input  logic         tick,
  input  logic         step,
  input  logic         ext_fall,
  input  logic         ext_en,
  input  logic         dir_up,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  input  logic         ovf_clr,
  input  logic         evt_clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_q,
  output logic         evt_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d, rld_d;
  logic         ovf_set, evt_set, evt_tgl;
  logic         at_max, at_rld;

  assign at_max = (cnt_q == '1);
  assign at_rld = (cnt_q == rld_q);

  always_comb begin
    cnt_d   = cnt_q;
    rld_d   = rld_q;
    ovf_set = 1'b0;
    evt_set = 1'b0;
    evt_tgl = 1'b0;
    if (tick) begin
      unique case (mode)
        MODE_CAPTURE: begin
          if (step) begin
            cnt_d   = cnt_q + ONE;
            ovf_set = at_max;
          end
          if (ext_en && ext_fall) begin
            rld_d   = cnt_q;
            evt_set = 1'b1;
          end
        end
        MODE_RELOAD: begin
          if (ext_en && ext_fall) begin
            cnt_d   = rld_q;
            evt_set = 1'b1;
            ovf_set = step && at_max;
          end else if (step) begin
            if (at_max) begin
              cnt_d   = rld_q;
              ovf_set = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        MODE_UPDOWN: begin
          if (step) begin
            if (dir_up) begin
              if (at_max) begin
                cnt_d   = rld_q;
                ovf_set = 1'b1;
                evt_tgl = 1'b1;
              end else begin
                cnt_d = cnt_q + ONE;
              end
            end else begin
              if (at_rld) begin
                cnt_d   = '1;
                ovf_set = 1'b1;
                evt_tgl = 1'b1;
              end else begin
                cnt_d = cnt_q - ONE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_we ? cnt_wdata : cnt_d;
      rld_q <= rld_we ? rld_wdata : rld_d;
      ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
      if (evt_tgl)      evt_q <= ~evt_q;
      else if (evt_set) evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRESCALE = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         cnt_sel_i,
  input  logic         cap_sel_i,
  input  logic         ext_en_i,
  input  logic         dn_en_i,
  input  logic         idle_sel_i,
  input  logic         cnt_pin_i,
  input  logic         dir_pin_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         rld_we_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic         ovf_clr_i,
  input  logic         evt_clr_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_o,
  output logic         evt_o,
  output logic         irq_o
);
  localparam int NPIN = 2;
  localparam int PIN_CNT = 0;
  localparam int PIN_DIR = 1;

  logic            active, tick, step;
  logic [NPIN-1:0] falls;
  crt_mode_e       mode;

  assign active = run_i & ~idle_sel_i;
  assign mode   = decode_mode(active, cap_sel_i, dn_en_i);

  crt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active),
    .tick (tick)
  );

  crt_edge_sampler #(.N(NPIN)) u_smp (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active),
    .tick (tick),
    .pin  ({dir_pin_i, cnt_pin_i}),
    .fall (falls)
  );

  assign step = cnt_sel_i ? falls[PIN_CNT] : 1'b1;

  crt_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .tick     (tick),
    .step     (step),
    .ext_fall (falls[PIN_DIR]),
    .ext_en   (ext_en_i),
    .dir_up   (dir_pin_i),
    .cnt_we   (cnt_we_i),
    .cnt_wdata(cnt_wdata_i),
    .rld_we   (rld_we_i),
    .rld_wdata(rld_wdata_i),
    .ovf_clr  (ovf_clr_i),
    .evt_clr  (evt_clr_i),
    .cnt_q    (count_o),
    .rld_q    (rld_o),
    .ovf_q    (ovf_o),
    .evt_q    (evt_o)
  );

  assign irq_o = ovf_o | (evt_o & ~dn_en_i);
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_i,
  input logic         cap_sel_i,
  input logic         dn_en_i,
  input logic         idle_sel_i,
  input logic         dir_pin_i,
  input logic         cnt_we_i,
  input logic         rld_we_i,
  input logic         ovf_clr_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] rld_o,
  input logic         ovf_o,
  input logic         irq_o
);
  // R4: a stopped or idled timer keeps its count unless software writes it
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run_i || idle_sel_i) && !cnt_we_i) |=> $stable(count_o));

  // R5: in capture mode the count only stays or steps up by one (wrapping)
  p_cap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !idle_sel_i && cap_sel_i && !cnt_we_i)
      |=> (count_o == $past(count_o) || count_o == ($past(count_o) + W'(1))));

  // R6: the capture/reload register changes only by write or in capture mode
  p_rld_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rld_we_i && !cap_sel_i) |=> $stable(rld_o));

  // R9: down-counting moves by one or reloads all ones
  p_down_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !idle_sel_i && !cap_sel_i && dn_en_i && !dir_pin_i && !cnt_we_i)
      |=> (count_o == $past(count_o) || count_o == ($past(count_o) - W'(1))
           || count_o == '1));

  // R10: in up/down mode the event flag alone never raises the request
  p_no_evt_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_en_i && !ovf_o) |-> !irq_o);

  // R11: the overflow flag is sticky until cleared
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind cap_reload_timer crt_checker #(.W(W)) u_chk (.*);

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb;
  localparam int PS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 0, cnt_sel_i = 0, cap_sel_i = 0, ext_en_i = 0, dn_en_i = 0, idle_sel_i = 0;
  logic cnt_pin_i = 0, dir_pin_i = 1;
  logic cnt_we_i = 0, rld_we_i = 0, ovf_clr_i = 0, evt_clr_i = 0;
  logic [15:0] cnt_wdata_i = '0, rld_wdata_i = '0;
  logic [15:0] count_o, rld_o;
  logic ovf_o, evt_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cap_reload_timer u_dut (.*);

  typedef struct packed {
    logic        cap;
    logic        dn;
    logic        dir;
    logic [15:0] start;
    logic [15:0] rld;
    logic [7:0]  ticks;
    logic [15:0] ecnt;
    logic        eovf;
    logic        eevt;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{1'b1, 1'b0, 1'b1, 16'hFFFE, 16'h0000, 8'd3, 16'h0001, 1'b1, 1'b0}, // R5 wrap
    '{1'b0, 1'b0, 1'b1, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 1'b1, 1'b0}, // R7 reload
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd5, 16'h0005, 1'b0, 1'b0}, // R2 plain
    '{1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hAAAA, 8'd1, 16'hAAAA, 1'b1, 1'b1}, // R8 up
    '{1'b0, 1'b1, 1'b0, 16'h0005, 16'h0003, 8'd2, 16'h0003, 1'b0, 1'b0}, // R9 down
    '{1'b0, 1'b1, 1'b0, 16'h0005, 16'h0003, 8'd3, 16'hFFFF, 1'b1, 1'b1}, // R9 match
    '{1'b0, 1'b1, 1'b0, 16'h0005, 16'h0003, 8'd4, 16'hFFFE, 1'b1, 1'b1}, // R9 after
    '{1'b0, 1'b1, 1'b0, 16'h0002, 16'h0000, 8'd6, 16'hFFFC, 1'b1, 1'b1}, // R9 zero
    '{1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 8'd2, 16'hFFFF, 1'b1, 1'b0}  // R10 twice
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mcycles(input int n);
    repeat (n * PS) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] c, input logic [15:0] r);
    @(negedge clk);
    run_i = 0;
    cnt_we_i = 1; cnt_wdata_i = c;
    rld_we_i = 1; rld_wdata_i = r;
    ovf_clr_i = 1; evt_clr_i = 1;
    @(negedge clk);
    cnt_we_i = 0; rld_we_i = 0; ovf_clr_i = 0; evt_clr_i = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 rld", rld_o, 0);
    chk("R1 flags", {ovf_o, evt_o, irq_o}, 0);

    // R12 software writes
    setup(16'h4321, 16'h8765);
    chk("R12 count write", count_o, 16'h4321);
    chk("R12 rld write", rld_o, 16'h8765);

    // vector table, timer function
    foreach (VEC[i]) begin
      setup(VEC[i].start, VEC[i].rld);
      cap_sel_i = VEC[i].cap; dn_en_i = VEC[i].dn; dir_pin_i = VEC[i].dir;
      cnt_sel_i = 0; ext_en_i = 0;
      run_i = 1;
      repeat (int'(VEC[i].ticks) * PS) @(posedge clk);
      @(negedge clk);
      run_i = 0;
      chk($sformatf("R2/R5/R7/R8/R9/R10 vec%0d count", i), count_o, VEC[i].ecnt);
      chk($sformatf("R5/R7/R8/R9 vec%0d ovf", i), ovf_o, VEC[i].eovf);
      chk($sformatf("R10 vec%0d evt", i), evt_o, VEC[i].eevt);
    end

    // R2 first step lands exactly PRESCALE clocks after run
    setup(16'h0000, 16'h0000);
    cap_sel_i = 0; dn_en_i = 0; dir_pin_i = 1; run_i = 1;
    repeat (PS - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 before first strobe", count_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 at first strobe", count_o, 1);
    run_i = 0;

    // R4 hold while stopped and while idled
    repeat (40) @(negedge clk);
    chk("R4 stopped", count_o, 1);
    idle_sel_i = 1; run_i = 1;
    mcycles(5);
    chk("R4 idle select", count_o, 1);
    idle_sel_i = 0; run_i = 0;

    // R3 counter function: edge lag and single count for held low
    setup(16'h0000, 16'h0000);
    cnt_sel_i = 1; cap_sel_i = 0; dn_en_i = 0; cnt_pin_i = 1; run_i = 1;
    mcycles(1);
    cnt_pin_i = 0;
    mcycles(1);
    chk("R3 no update in detect cycle", count_o, 0);
    mcycles(1);
    chk("R3 update next cycle", count_o, 1);
    mcycles(3);
    chk("R3 held low counts once", count_o, 1);
    cnt_pin_i = 1; mcycles(1); cnt_pin_i = 0; mcycles(2);
    chk("R3 second edge", count_o, 2);
    run_i = 0; cnt_sel_i = 0;

    // R6 capture on direction-pin falling edge
    setup(16'h0100, 16'h0000);
    cap_sel_i = 1; ext_en_i = 1; dir_pin_i = 1; run_i = 1;
    mcycles(2);
    dir_pin_i = 0;
    mcycles(1);
    chk("R6 no capture yet", rld_o, 0);
    mcycles(1);
    run_i = 0;
    chk("R6 captured value", rld_o, 16'h0103);
    chk("R6 count continues", count_o, 16'h0104);
    chk("R6 event flag and irq", {evt_o, irq_o}, 2'b11);

    // R6 external enable at 0 ignores the edge
    setup(16'h0200, 16'h0103);
    ext_en_i = 0; dir_pin_i = 1; run_i = 1;
    mcycles(1);
    dir_pin_i = 0;
    mcycles(3);
    run_i = 0;
    chk("R6 ignored capture", rld_o, 16'h0103);
    chk("R6 ignored event", evt_o, 0);

    // R7 forced reload by external edge
    setup(16'h0010, 16'h8000);
    cap_sel_i = 0; dn_en_i = 0; ext_en_i = 1; dir_pin_i = 1; run_i = 1;
    mcycles(2);
    dir_pin_i = 0;
    mcycles(1);
    chk("R7 before forced reload", count_o, 16'h0013);
    mcycles(1);
    run_i = 0;
    chk("R7 forced reload", count_o, 16'h8000);
    chk("R7 event flag", evt_o, 1);
    ext_en_i = 0;

    // R11 interrupt masking and sticky flags
    setup(16'hFFFF, 16'hAAAA);
    dn_en_i = 1; dir_pin_i = 1; run_i = 1;
    mcycles(1);
    run_i = 0;
    chk("R11 irq from ovf", irq_o, 1);
    repeat (5) @(negedge clk);
    chk("R11 flags sticky", {ovf_o, evt_o}, 2'b11);
    ovf_clr_i = 1; @(negedge clk); ovf_clr_i = 0;
    chk("R11 evt masked in updown", {ovf_o, evt_o, irq_o}, 3'b010);
    dn_en_i = 0; #1;
    chk("R11 evt raises irq", irq_o, 1);
    evt_clr_i = 1; @(negedge clk); evt_clr_i = 0;
    chk("R11 evt cleared", {evt_o, irq_o}, 2'b00);

    done = 1;
    finish_run();
  end
endmodule